// File: doc/BRIEF.md
# Shared-Path Virtual Channel Link

This block carries several independent virtual channels over one shared flit path. Each channel has two sides. On the sender side a source raises a request with a flit on its data lines. On the receiver side a sink raises a request when it has room for one flit. A channel may compete for the shared path only when both of its sides are ready. A round-robin arbiter picks one such channel. Its one-hot select steers both the sender multiplexer and the receiver demultiplexer.

The chosen flit is written onto an internal rail bus in 1-of-4 code: every pair of data bits drives exactly one wire of a four-wire group. The controller waits until every group shows a value, which is completion detection. It then acknowledges the chosen channel on both sides and shows the decoded flit on that channel's receive port only. Both handshakes are four-phase. After both requests have fallen, the rails return to zero and the controller waits until they read empty. Only then does it arbitrate again.

Because a sink's free-slot request gates arbitration, a flit never crosses the path unless the far end can take it. A channel with only one side ready simply stays out of arbitration and never holds the path.

Top module: `vc_link`

## Requirements
- R1: While reset is high, and on the first cycle after it falls with all requests low, every sender acknowledge, every receiver acknowledge and every receive data bit is zero.
- R2: A channel is acknowledged only if its sender request and its receiver request were both high when it was chosen. A channel with only one side ready is never acknowledged.
- R3: At most one channel is acknowledged at a time. The sender acknowledge vector always equals the receiver acknowledge vector.
- R4: While channel c is acknowledged, its receive data port carries exactly the flit that channel c's sender offered when it was chosen. A receive data port whose acknowledge is low reads all zeros. Flits of each channel arrive in the order sent, with none lost.
- R5: Both acknowledges stay high while either request of the chosen channel is high. They fall on the clock edge that first sees both requests low.
- R6: When the link is idle and a channel's two requests are both high before a clock edge, its acknowledges are high after the second such edge and not after the first.
- R7: Grants rotate. After channel i is served, the next grant goes to the first ready channel in the order i+1, i+2, … modulo the channel count.
- R8: A channel whose sender is ready but whose receiver is not does not delay other ready channels.
- R9: On the internal rails each group of four wires carries at most one high wire. A data pair of value v drives wire v of its group. Every group is one-hot once a flit is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| sndReq | input | NUM_VC | Per-channel flit-ready request from the sources |
| sndData | input | NUM_VC*FLIT_W | Per-channel flit words, channel c at bits c*FLIT_W upward |
| sndAck | output | NUM_VC | Per-channel acknowledge to the sources |
| rcvReq | input | NUM_VC | Per-channel free-slot request from the sinks |
| rcvAck | output | NUM_VC | Per-channel acknowledge to the sinks, qualifying rcvData |
| rcvData | output | NUM_VC*FLIT_W | Per-channel delivered flit, zero unless that channel is acknowledged |

## Verification
The first directed case gives a channel a ready sender with no sink slot, which separates request joining from plain sender arbitration. Single-channel transfers then pin the two-edge rise and the one-edge fall of the acknowledges. With all four channels ready at once, the test shows whether the pointer rotates or sticks at the lowest channel. A case with one half-ready channel next to a fully ready one shows whether a stall spreads. A random phase then runs sequence-tagged sources against sinks with uneven readiness. There the scoreboard catches reordering, loss and flits that cross to the wrong channel.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HOLD = 2'd2,
    ST_RTZ  = 2'd3
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cap;   // load rails from the steered sender word
    logic clr;   // return rails to zero
    logic show;  // present decoded flit on the selected receive port
  } pathCmd_t;

  function automatic logic [3:0] enc4(input logic [1:0] pair);
    logic [3:0] w;
    w = 4'b0000;
    w[pair] = 1'b1;
    return w;
  endfunction

  function automatic logic [1:0] dec4(input logic [3:0] w);
    return {w[3] | w[2], w[3] | w[1]};
  endfunction

endpackage

// File: rtl/vc_link_arb.sv
module vc_link_arb #(
  parameter int NUM_VC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_VC-1:0] req,
  input  logic              take,
  output logic [NUM_VC-1:0] grant
);
  localparam int IDXW = $clog2(NUM_VC);

  logic [IDXW-1:0] ptr;
  logic [IDXW-1:0] pick;
  logic [IDXW-1:0] probe;
  logic            found;

  // scan from the pointer; NUM_VC is a power of two so index wraps freely
  always_comb begin
    grant = '0;
    pick  = '0;
    probe = '0;
    found = 1'b0;
    for (int off = 0; off < NUM_VC; off++) begin
      probe = ptr + IDXW'(off);
      if (!found && req[probe]) begin
        grant[probe] = 1'b1;
        pick         = probe;
        found        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take && found) ptr <= pick + IDXW'(1);
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0)); // R2

endmodule

// File: rtl/vc_link_ctrl.sv
module vc_link_ctrl
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_VC-1:0] sndReq,
  input  logic [NUM_VC-1:0] rcvReq,
  input  logic [NUM_VC-1:0] grant,
  input  logic              railsFull,
  input  logic              railsEmpty,
  output logic [NUM_VC-1:0] joinedReq,
  output logic              take,
  output logic [NUM_VC-1:0] steerSel,
  output pathCmd_t          cmd,
  output logic [NUM_VC-1:0] sndAck,
  output logic [NUM_VC-1:0] rcvAck
);

  linkState_t       state, stateNxt;
  logic [NUM_VC-1:0] selReg;
  logic              selBusy;

  // a channel competes only with both sides ready
  for (genvar c = 0; c < NUM_VC; c++) begin : g_join
    assign joinedReq[c] = sndReq[c] & rcvReq[c];
  end

  assign selBusy  = |(selReg & (sndReq | rcvReq));
  assign steerSel = (state == ST_IDLE) ? grant : selReg;

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    take     = 1'b0;
    unique case (state)
      ST_IDLE: if (|joinedReq) begin
        cmd.cap  = 1'b1;
        take     = 1'b1;
        stateNxt = ST_LOAD;
      end
      ST_LOAD: if (railsFull) stateNxt = ST_HOLD;
      ST_HOLD: begin
        cmd.show = 1'b1;
        if (!selBusy) begin
          cmd.clr  = 1'b1;
          stateNxt = ST_RTZ;
        end
      end
      ST_RTZ: if (railsEmpty) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      selReg <= '0;
    end else begin
      state <= stateNxt;
      if (cmd.cap) selReg <= grant;
    end
  end

  assign sndAck = (state == ST_HOLD) ? selReg : '0;
  assign rcvAck = (state == ST_HOLD) ? selReg : '0;

  AST_CAP_JOINED: assert property (@(posedge clk) disable iff (rst)
    cmd.cap |-> ((|grant) && ((grant & sndReq & rcvReq) == grant))); // R2
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sndAck) && (sndAck == rcvAck)); // R3
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|(sndAck & (sndReq | rcvReq))) |=> $stable(sndAck)); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    ((|sndAck) && !(|(sndAck & (sndReq | rcvReq)))) |=> (sndAck == '0)); // R5

endmodule

// File: rtl/vc_link_path.sv
module vc_link_path
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pathCmd_t                 cmd,
  input  logic [NUM_VC-1:0]        steerSel,
  input  logic [NUM_VC*FLIT_W-1:0] sndData,
  output logic                     railsFull,
  output logic                     railsEmpty,
  output logic [NUM_VC*FLIT_W-1:0] rcvData
);
  localparam int NGRP   = FLIT_W / 2;
  localparam int RAIL_W = 4 * NGRP;

  logic [FLIT_W-1:0] muxWord;
  logic [FLIT_W-1:0] decWord;
  logic [RAIL_W-1:0] rails;
  logic [NGRP-1:0]   grpSet;

  // sender multiplexer driven by the shared one-hot select
  always_comb begin
    muxWord = '0;
    for (int c = 0; c < NUM_VC; c++)
      if (steerSel[c]) muxWord = muxWord | sndData[c*FLIT_W +: FLIT_W];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst || cmd.clr) rails[4*g +: 4] <= 4'b0000;
      else if (cmd.cap)   rails[4*g +: 4] <= enc4(muxWord[2*g +: 2]);
    end
    assign grpSet[g]         = |rails[4*g +: 4];
    assign decWord[2*g +: 2] = dec4(rails[4*g +: 4]);

    AST_RAIL_GROUP: assert property (@(posedge clk) disable iff (rst)
      $countones(rails[4*g +: 4]) <= 1); // R9
  end

  assign railsFull  = &grpSet;
  assign railsEmpty = ~|grpSet;

  // receiver demultiplexer on the same select
  for (genvar c = 0; c < NUM_VC; c++) begin : g_demux
    assign rcvData[c*FLIT_W +: FLIT_W] =
      (cmd.show && steerSel[c]) ? decWord : '0;
  end

  AST_LOAD_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    cmd.cap |=> railsFull); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cmd.clr |=> railsEmpty); // R4

endmodule

// File: rtl/vc_link.sv
module vc_link
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_VC-1:0]        sndReq,
  input  logic [NUM_VC*FLIT_W-1:0] sndData,
  output logic [NUM_VC-1:0]        sndAck,
  input  logic [NUM_VC-1:0]        rcvReq,
  output logic [NUM_VC-1:0]        rcvAck,
  output logic [NUM_VC*FLIT_W-1:0] rcvData
);

  logic [NUM_VC-1:0] joinedReq;
  logic [NUM_VC-1:0] grant;
  logic [NUM_VC-1:0] steerSel;
  logic              take;
  logic              railsFull;
  logic              railsEmpty;
  pathCmd_t          cmd;

  vc_link_arb #(.NUM_VC(NUM_VC)) u_arb (
    .clk(clk), .rst(rst), .req(joinedReq), .take(take), .grant(grant)
  );

  vc_link_ctrl #(.NUM_VC(NUM_VC)) u_ctrl (
    .clk(clk), .rst(rst), .sndReq(sndReq), .rcvReq(rcvReq), .grant(grant),
    .railsFull(railsFull), .railsEmpty(railsEmpty), .joinedReq(joinedReq),
    .take(take), .steerSel(steerSel), .cmd(cmd),
    .sndAck(sndAck), .rcvAck(rcvAck)
  );

  vc_link_path #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_path (
    .clk(clk), .rst(rst), .cmd(cmd), .steerSel(steerSel), .sndData(sndData),
    .railsFull(railsFull), .railsEmpty(railsEmpty), .rcvData(rcvData)
  );

  AST_DATA_GATED: assert property (@(posedge clk) disable iff (rst)
    (rcvAck == '0) |-> (rcvData == '0)); // R4

endmodule

// File: tb/vc_link_bench.sv
module vc_link_bench;
  localparam int NV = 4;
  localparam int FW = 16;
  localparam int FLITS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NV-1:0]    sndReq, rcvReq, sndAck, rcvAck;
  logic [NV*FW-1:0] sndData, rcvData;

  logic          sReq [NV];
  logic          rReq [NV];
  logic [FW-1:0] sWord [NV];
  logic [FW-1:0] expQ [NV][$];

  int applied = 0;
  int miscompares = 0;
  bit monOn = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NV; c++) begin
      sndReq[c] = sReq[c];
      rcvReq[c] = rReq[c];
      sndData[c*FW +: FW] = sWord[c];
    end
  end

  vc_link #(.NUM_VC(NV), .FLIT_W(FW)) u_vc_link (
    .clk(clk), .rst(rst), .sndReq(sndReq), .sndData(sndData), .sndAck(sndAck),
    .rcvReq(rcvReq), .rcvAck(rcvAck), .rcvData(rcvData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] rxWord(input int ch);
    return rcvData[ch*FW +: FW];
  endfunction

  // R3/R4 monitor: one-hot matching acks, ungated ports stay zero
  always @(negedge clk) begin
    if (monOn && !rst) begin
      check($onehot0(sndAck) && (sndAck == rcvAck), "R3 ack vectors",
            {sndAck, rcvAck}, {rcvAck, rcvAck});
      for (int c = 0; c < NV; c++)
        if (!rcvAck[c])
          check(rxWord(c) == '0, "R4 idle port zero", rxWord(c), 0);
    end
  end

  task automatic sender(input int ch, input int maxGap);
    for (int s = 0; s < FLITS; s++) begin
      repeat ($urandom_range(0, maxGap)) @(negedge clk);
      sWord[ch] = {4'(ch), 12'(s)};
      expQ[ch].push_back(sWord[ch]);
      sReq[ch] = 1'b1;
      do @(negedge clk); while (!sndAck[ch]);
      sReq[ch] = 1'b0;
      do @(negedge clk); while (sndAck[ch]);
    end
  endtask

  // scoreboard monitor: pops per channel as flits are delivered
  task automatic receiver(input int ch, input int maxGap);
    for (int s = 0; s < FLITS; s++) begin
      logic [FW-1:0] want;
      repeat ($urandom_range(0, maxGap)) @(negedge clk);
      rReq[ch] = 1'b1;
      do @(negedge clk); while (!rcvAck[ch]);
      want = (expQ[ch].size() > 0) ? expQ[ch].pop_front() : 'x;
      check(rxWord(ch) === want, "R4 in-order delivery", rxWord(ch), want);
      rReq[ch] = 1'b0;
      do @(negedge clk); while (rcvAck[ch]);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int got;
    for (int c = 0; c < NV; c++) begin
      sReq[c] = 0; rReq[c] = 0; sWord[c] = '0;
    end
    repeat (3) @(negedge clk);
    check(sndAck == 0 && rcvAck == 0 && rcvData == 0, "R1 in reset",
          {sndAck, rcvAck}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sndAck == 0 && rcvAck == 0 && rcvData == 0, "R1 after reset",
          {sndAck, rcvAck}, 0);
    monOn = 1'b1;

    // R2: sender ready, no free slot -> never granted
    sWord[0] = 16'hA5C3; sReq[0] = 1;
    repeat (6) @(negedge clk);
    check(sndAck == 0, "R2 half ready", sndAck, 0);

    // R6: rise after second edge
    rReq[0] = 1;
    @(negedge clk);
    check(sndAck == 0, "R6 not after first edge", sndAck, 0);
    @(negedge clk);
    check(sndAck == 4'b0001 && rcvAck == 4'b0001, "R6 ack after second edge",
          sndAck, 1);
    check(rxWord(0) == 16'hA5C3, "R4 directed data", rxWord(0), 16'hA5C3);

    // R5: held while one request remains
    sReq[0] = 0;
    repeat (3) @(negedge clk);
    check(sndAck == 4'b0001, "R5 held by receiver req", sndAck, 1);
    rReq[0] = 0;
    @(negedge clk);
    check(sndAck == 0 && rcvAck == 0, "R5 drop on next edge", sndAck, 0);
    repeat (3) @(negedge clk);

    // R7: all ready, expect rotation 1,2,3,0
    for (int c = 0; c < NV; c++) begin
      sWord[c] = 16'h1000 * 16'(c + 1) + 16'h0055; sReq[c] = 1; rReq[c] = 1;
    end
    for (int k = 0; k < NV; k++) begin
      do @(negedge clk); while (sndAck == 0);
      got = 0;
      for (int c = 0; c < NV; c++) if (sndAck[c]) got = c;
      check(got == (k + 1) % NV, "R7 rotation", got, (k + 1) % NV);
      check(rxWord(got) == sWord[got], "R4 rotation data", rxWord(got), sWord[got]);
      sReq[got] = 0; rReq[got] = 0;
      do @(negedge clk); while (sndAck != 0);
      if (k < NV - 1) begin sReq[got] = 1; rReq[got] = 1; end
    end
    for (int c = 0; c < NV; c++) begin sReq[c] = 0; rReq[c] = 0; end
    repeat (4) @(negedge clk);

    // R8: channel 2 stalled at receiver, channel 3 proceeds
    sWord[2] = 16'h2222; sReq[2] = 1;
    sWord[3] = 16'h3333; sReq[3] = 1; rReq[3] = 1;
    repeat (2) @(negedge clk);
    check(sndAck == 4'b1000, "R8 stall does not block", sndAck, 4'b1000);
    check(rxWord(3) == 16'h3333, "R8 data of free channel", rxWord(3), 16'h3333);
    sReq[3] = 0; rReq[3] = 0; sReq[2] = 0;
    repeat (4) @(negedge clk);
    check(sndAck == 0, "R2 stalled channel never acked", sndAck, 0);

    // random phase: sequence-tagged scoreboard
    fork
      for (int c = 0; c < NV; c++) begin
        automatic int ch = c;
        fork
          sender(ch, 5);
          receiver(ch, (ch == 1) ? 40 : 6);
        join_none
      end
    join
    wait fork;
    for (int c = 0; c < NV; c++)
      check(expQ[c].size() == 0, "R4 lossless", expQ[c].size(), 0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule